// File: doc/BRIEF.md
# Vectored Interrupt Priority Acceptance Unit

This block tracks interrupt vectors for a single processor. It keeps three bit vectors, one bit per vector number. The request set records vectors that are waiting. The in-service set records vectors the processor has taken but not yet retired. The trigger set records which waiting or active vectors are level-sensitive. From these sets and a task-priority register it derives a processor priority. It raises an interrupt request when the best waiting vector lies in a class above that priority.

The processor takes an interrupt by pulsing an acknowledge strobe. In that same cycle it reads the chosen vector. If nothing deliverable is waiting, it reads the spurious vector instead. It retires an interrupt by writing the end-of-interrupt register. For a level-sensitive vector, that retirement is announced on a one-cycle broadcast output so that the source can re-sample its line. A separate deassert input withdraws a waiting level-sensitive request.

A small register port covers three writable registers: task priority, the spurious/enable register and end-of-interrupt. It also gives read access to the derived processor priority.

Top module: `vec_prio_accept`

## Requirements
- R1: After reset all three vector sets are empty, task priority reads 0x00, the spurious/enable register reads 0x0FF, intReq is low and no broadcast is emitted.
- R2: The best waiting vector is the highest-numbered set bit of the request set, and it is the one an acknowledge delivers first.
- R3: Processor priority (read at regSel=1) equals task priority when task priority bits [7:4] are at least the class (bits [7:4]) of the highest in-service vector. Otherwise it equals that class shifted left by four; an empty in-service set counts as vector 0.
- R4: While bit 8 of the spurious/enable register is 0, intReq stays low, and an acknowledge returns that register's bits [7:0] and changes no vector state.
- R5: When processor priority is nonzero and the class of the best waiting vector is at or below the processor priority class, intReq is low, and an acknowledge returns the spurious vector and changes no vector state.
- R6: An acknowledge of a deliverable vector returns it on ackVector in the strobe cycle, clears its request bit and sets its in-service bit.
- R7: A request sets its request bit and sets its trigger bit when reqLevel=1, or clears it when reqLevel=0.
- R8: A write at regSel=2 clears the highest in-service bit. If that vector's trigger bit is set and bit 12 of the spurious/enable register is 0, eoiBcastValid pulses for one cycle, in the next cycle, with eoiBcastVec equal to the vector.
- R9: Writes at regSel=3 keep only data bits [8:0] and bit 12, and every other bit reads back 0. Writes at regSel=0 keep bits [7:0].
- R10: A deassert clears the named vector's request bit only when its trigger bit is set; for an edge-triggered vector it has no effect.
- R11: intReq is derived directly from registered state, so it reflects an acknowledge, retirement, request or register write in the cycle after the clock edge that applied it.
- R12: When a request and an acknowledge name the same vector in one cycle, the acknowledge is applied first. The request bit is then set again, so the vector ends up both waiting and in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Incoming interrupt request strobe |
| reqVec | input | 8 | Vector of the incoming request |
| reqLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| dropValid | input | 1 | Level-line deassert strobe |
| dropVec | input | 8 | Vector whose level line deasserted |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 task priority, 1 processor priority (read-only), 2 end-of-interrupt (write-only), 3 spurious/enable |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regSel (combinational) |
| ackStrobe | input | 1 | Interrupt acknowledge |
| ackVector | output | 8 | Vector returned on acknowledge |
| intReq | output | 1 | Interrupt request to the processor |
| eoiBcastValid | output | 1 | End-of-interrupt broadcast pulse |
| eoiBcastVec | output | 8 | Vector carried by the broadcast |

## Verification
The bench builds the block with its default 32-bit word grouping over 256 vectors. This places vectors in several different words: 0x05, 0x21, 0x45, 0x9F and 0xE7. Ordering therefore depends on the selection across words as well as within a word. A reference model kept in the bench predicts every acknowledged vector, every broadcast and the intReq level after each operation. Directed sequences reach nested in-service classes, task priority equal to the in-service class, directed-retirement suppression, deasserts of edge vectors and the same-vector request/acknowledge collision.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  localparam int VEC_W = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLS_W = VEC_W - 4;
  localparam int SVR_W = 13;
  localparam int SVR_EN_BIT = 8;
  localparam int SVR_DIR_BIT = 12;

  localparam logic [1:0] SEL_TPR = 2'd0;
  localparam logic [1:0] SEL_PPR = 2'd1;
  localparam logic [1:0] SEL_EOI = 2'd2;
  localparam logic [1:0] SEL_SVR = 2'd3;

  typedef struct packed {
    logic             reqSet;
    logic [VEC_W-1:0] reqVec;
    logic             reqLevel;
    logic             dropSet;
    logic [VEC_W-1:0] dropVec;
    logic             ackTake;
    logic [VEC_W-1:0] ackVec;
    logic             eoiTake;
    logic [VEC_W-1:0] eoiVec;
  } vpaStrobes_t;
endpackage

// File: rtl/vpa_highest.sv
module vpa_highest #(
  parameter int NUM_BITS = 256,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(NUM_BITS),
  localparam int NUM_WORDS = NUM_BITS / WORD_W,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic [NUM_BITS-1:0] vecIn,
  output logic [IDX_W-1:0]    hiIdx,
  output logic                anySet
);
  logic [BIT_W-1:0] wordHi  [NUM_WORDS];
  logic             wordAny [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    logic [BIT_W-1:0] localHi;
    always_comb begin
      localHi = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (vecIn[w*WORD_W + b]) localHi = BIT_W'(b);
      end
    end
    assign wordHi[w]  = localHi;
    assign wordAny[w] = |vecIn[w*WORD_W +: WORD_W];
  end

  always_comb begin
    hiIdx  = '0;
    anySet = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wordAny[w]) begin
        hiIdx  = IDX_W'(w * WORD_W) | IDX_W'(wordHi[w]);
        anySet = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpa_vectors.sv
module vpa_vectors
  import vpa_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  vpaStrobes_t      strb,
  output logic [VEC_W-1:0] irrHi,
  output logic             irrAny,
  output logic [VEC_W-1:0] isrHi,
  output logic             isrAny,
  output logic             tmrAtIsrHi
);
  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic [NUM_VEC-1:0] irrNext, isrNext, tmrNext;

  vpa_highest #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) irrPick_i (
    .vecIn(irr), .hiIdx(irrHi), .anySet(irrAny)
  );
  vpa_highest #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) isrPick_i (
    .vecIn(isr), .hiIdx(isrHi), .anySet(isrAny)
  );

  assign tmrAtIsrHi = tmr[isrHi];

  always_comb begin
    irrNext = irr;
    isrNext = isr;
    tmrNext = tmr;
    if (strb.eoiTake) isrNext[strb.eoiVec] = 1'b0;
    if (strb.ackTake) begin
      irrNext[strb.ackVec] = 1'b0;
      isrNext[strb.ackVec] = 1'b1;
    end
    if (strb.dropSet && tmr[strb.dropVec]) irrNext[strb.dropVec] = 1'b0;
    if (strb.reqSet) begin
      irrNext[strb.reqVec] = 1'b1;
      tmrNext[strb.reqVec] = strb.reqLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
    end else begin
      irr <= irrNext;
      isr <= isrNext;
      tmr <= tmrNext;
    end
  end

  p_req_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.reqSet |=> irr[$past(strb.reqVec)] && (tmr[$past(strb.reqVec)] == $past(strb.reqLevel)));

  p_ack_to_service_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> isr[$past(strb.ackVec)]);

  p_ack_clears_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake && !(strb.reqSet && strb.reqVec == strb.ackVec) |=> !irr[$past(strb.ackVec)]);

  p_eoi_retires_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.eoiTake && !(strb.ackTake && strb.ackVec == strb.eoiVec) |=> !isr[$past(strb.eoiVec)]);

  p_drop_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropSet && tmr[strb.dropVec] && !(strb.reqSet && strb.reqVec == strb.dropVec)
      |=> !irr[$past(strb.dropVec)]);

  p_collide_keeps_r12: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake && strb.reqSet && strb.reqVec == strb.ackVec
      |=> irr[$past(strb.ackVec)] && isr[$past(strb.ackVec)]);
endmodule

// File: rtl/vpa_ctrl.sv
module vpa_ctrl
  import vpa_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVec,
  input  logic             reqLevel,
  input  logic             dropValid,
  input  logic [VEC_W-1:0] dropVec,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             ackStrobe,
  output logic [VEC_W-1:0] ackVector,
  output logic             intReq,
  output logic             eoiBcastValid,
  output logic [VEC_W-1:0] eoiBcastVec,
  input  logic [VEC_W-1:0] irrHi,
  input  logic             irrAny,
  input  logic [VEC_W-1:0] isrHi,
  input  logic             isrAny,
  input  logic             tmrAtIsrHi,
  output vpaStrobes_t      strb
);
  logic [VEC_W-1:0] tpr;
  logic [SVR_W-1:0] svr;
  logic [CLS_W-1:0] isrClass;
  logic [VEC_W-1:0] ppr;
  logic             swEnable, directedEoi, masked, deliverable, eoiTake;

  assign swEnable    = svr[SVR_EN_BIT];
  assign directedEoi = svr[SVR_DIR_BIT];
  assign isrClass    = isrAny ? isrHi[VEC_W-1:4] : '0;
  assign ppr         = (tpr[VEC_W-1:4] >= isrClass) ? tpr : {isrClass, 4'b0000};
  assign masked      = (ppr != '0) && (irrHi[VEC_W-1:4] <= ppr[VEC_W-1:4]);
  assign deliverable = swEnable && irrAny && !masked;
  assign intReq      = deliverable;
  assign ackVector   = deliverable ? irrHi : svr[VEC_W-1:0];
  assign eoiTake     = regWe && (regSel == SEL_EOI) && isrAny;

  always_comb begin
    strb          = '0;
    strb.reqSet   = reqValid;
    strb.reqVec   = reqVec;
    strb.reqLevel = reqLevel;
    strb.dropSet  = dropValid;
    strb.dropVec  = dropVec;
    strb.ackTake  = ackStrobe && deliverable;
    strb.ackVec   = irrHi;
    strb.eoiTake  = eoiTake;
    strb.eoiVec   = isrHi;
  end

  always_comb begin
    case (regSel)
      SEL_TPR: regRdata = 32'(tpr);
      SEL_PPR: regRdata = 32'(ppr);
      SEL_SVR: regRdata = 32'(svr);
      default: regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tpr           <= '0;
      svr           <= SVR_W'(9'h0FF);
      eoiBcastValid <= 1'b0;
      eoiBcastVec   <= '0;
    end else begin
      if (regWe && regSel == SEL_TPR) tpr <= regWdata[VEC_W-1:0];
      if (regWe && regSel == SEL_SVR)
        svr <= {regWdata[SVR_DIR_BIT], 3'b000, regWdata[SVR_EN_BIT:0]};
      eoiBcastValid <= eoiTake && tmrAtIsrHi && !directedEoi;
      eoiBcastVec   <= isrHi;
    end
  end

  p_disabled_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
    !swEnable |-> !intReq && ackVector == svr[VEC_W-1:0]);

  p_masked_spurious_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe && !intReq |-> ackVector == svr[VEC_W-1:0]);

  p_ppr_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    isrAny |-> ppr[VEC_W-1:4] >= isrHi[VEC_W-1:4] && ppr[VEC_W-1:4] >= tpr[VEC_W-1:4]);

  p_bcast_after_eoi_r8: assert property (@(posedge clk) disable iff (!rstN)
    eoiBcastValid |-> $past(regWe) && $past(regSel) == SEL_EOI && !$past(directedEoi));

  p_svr_zero_bits_r9: assert property (@(posedge clk) disable iff (!rstN)
    regSel == SEL_SVR |-> regRdata[31:13] == '0 && regRdata[11:9] == '0);
endmodule

// File: rtl/vec_prio_accept.sv
module vec_prio_accept
  import vpa_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVec,
  input  logic             reqLevel,
  input  logic             dropValid,
  input  logic [VEC_W-1:0] dropVec,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             ackStrobe,
  output logic [VEC_W-1:0] ackVector,
  output logic             intReq,
  output logic             eoiBcastValid,
  output logic [VEC_W-1:0] eoiBcastVec
);
  vpaStrobes_t      strb;
  logic [VEC_W-1:0] irrHi, isrHi;
  logic             irrAny, isrAny, tmrAtIsrHi;

  vpa_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVec(reqVec), .reqLevel(reqLevel),
    .dropValid(dropValid), .dropVec(dropVec),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .ackStrobe(ackStrobe), .ackVector(ackVector), .intReq(intReq),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVec(eoiBcastVec),
    .irrHi(irrHi), .irrAny(irrAny), .isrHi(isrHi), .isrAny(isrAny),
    .tmrAtIsrHi(tmrAtIsrHi), .strb(strb)
  );

  vpa_vectors #(.WORD_W(WORD_W)) vectors_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .irrHi(irrHi), .irrAny(irrAny), .isrHi(isrHi), .isrAny(isrAny),
    .tmrAtIsrHi(tmrAtIsrHi)
  );
endmodule

// File: tb/vec_prio_accept_tb_top.sv
module vec_prio_accept_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqLevel = 1'b0, dropValid = 1'b0;
  logic [7:0]  reqVec = '0, dropVec = '0;
  logic        regWe = 1'b0, ackStrobe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  ackVector, eoiBcastVec;
  logic        intReq, eoiBcastValid;

  always #5 clk = ~clk;

  vec_prio_accept dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVec(reqVec), .reqLevel(reqLevel),
    .dropValid(dropValid), .dropVec(dropVec),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .ackStrobe(ackStrobe), .ackVector(ackVector), .intReq(intReq),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVec(eoiBcastVec)
  );

  int nChecks = 0;
  int nFails = 0;
  int ackQ[$];
  string ackTagQ[$];
  int bcastQ[$];

  // reference state
  logic [255:0] mIrr = '0, mIsr = '0, mTmr = '0;
  int mTpr = 0;
  int mSvr = 'h0FF;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int hiOf(logic [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int modelPpr();
    int h = hiOf(mIsr);
    int c = (h < 0) ? 0 : (h >> 4);
    return ((mTpr >> 4) >= c) ? mTpr : (c << 4);
  endfunction

  function automatic bit modelDeliver();
    int h = hiOf(mIrr);
    int p = modelPpr();
    if (!mSvr[8] || h < 0) return 1'b0;
    if (p != 0 && (h >> 4) <= (p >> 4)) return 1'b0;
    return 1'b1;
  endfunction

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rstN) begin
      if (ackStrobe) begin
        if (ackQ.size() == 0) chk("R6 unexpected ack", 1, 0);
        else chk(ackTagQ.pop_front(), int'(ackVector), ackQ.pop_front());
      end
      if (eoiBcastValid) begin
        if (bcastQ.size() == 0) chk("R8 unexpected broadcast", int'(eoiBcastVec), -1);
        else chk("R8 broadcast vector", int'(eoiBcastVec), bcastQ.pop_front());
      end
    end
  end

  // one operation cycle; model applies retire, acknowledge, deassert, request in that order
  task automatic opCycle(bit rq, int rv, bit rl, bit ak, bit dr, int dv, bit eo, string tag);
    int ih;
    int rh;
    @(posedge clk); #1;
    reqValid = rq; reqVec = 8'(rv); reqLevel = rl;
    ackStrobe = ak; dropValid = dr; dropVec = 8'(dv);
    regWe = eo; regSel = eo ? 2'd2 : 2'd0; regWdata = '0;
    if (ak) begin
      rh = hiOf(mIrr);
      ackTagQ.push_back({tag, " ack vector"});
      ackQ.push_back(modelDeliver() ? rh : (mSvr & 'hFF));
    end
    ih = hiOf(mIsr);
    if (eo && ih >= 0) begin
      if (mTmr[ih] && !mSvr[12]) bcastQ.push_back(ih);
      mIsr[ih] = 1'b0;
    end
    if (ak && modelDeliver()) begin
      mIrr[rh] = 1'b0;
      mIsr[rh] = 1'b1;
    end
    if (dr && mTmr[dv]) mIrr[dv] = 1'b0;
    if (rq) begin
      mIrr[rv] = 1'b1;
      mTmr[rv] = rl;
    end
    @(posedge clk); #1;
    reqValid = 0; ackStrobe = 0; dropValid = 0; regWe = 0;
    @(negedge clk);
    chk({tag, " R11 intReq"}, int'(intReq), int'(modelDeliver()));
  endtask

  task automatic regWr(int sel, int data);
    @(posedge clk); #1;
    regWe = 1; regSel = 2'(sel); regWdata = data;
    if (sel == 0) mTpr = data & 'hFF;
    if (sel == 3) mSvr = data & 'h11FF;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic regRd(int sel, int exp, string tag);
    @(posedge clk); #1;
    regSel = 2'(sel);
    @(negedge clk);
    chk(tag, int'(regRdata), exp);
  endtask

  task automatic req(int v, bit l, string tag);
    opCycle(1, v, l, 0, 0, 0, 0, tag);
  endtask
  task automatic ack(string tag);
    opCycle(0, 0, 0, 1, 0, 0, 0, tag);
  endtask
  task automatic eoi(string tag);
    opCycle(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 intReq after reset", int'(intReq), 0);
    chk("R1 broadcast after reset", int'(eoiBcastValid), 0);
    regRd(0, 'h00, "R1 task priority reset");
    regRd(3, 'h0FF, "R1 spurious register reset");
    regRd(1, 'h00, "R1 processor priority reset");

    // disabled: no request, acknowledge gives spurious
    req('h45, 0, "R4 disabled request");
    ack("R4 disabled");
    regWr(3, 'hFFFF_E1FF);
    regRd(3, 'h01FF, "R9 spurious write masking");
    @(negedge clk);
    chk("R4 enable raises intReq", int'(intReq), 1);

    ack("R6 first");
    regRd(1, 'h40, "R3 priority from in-service class");
    req('h30, 0, "R5 lower class");
    ack("R5 masked");
    req('h52, 0, "R2 higher class");
    ack("R6 nested");
    regRd(1, 'h50, "R3 nested priority");
    eoi("R8 edge retire");
    eoi("R8 second retire");
    regRd(1, 'h00, "R3 empty service");
    ack("R6 released");

    regWr(0, 'h3A);
    regRd(1, 'h3A, "R3 task priority equal class");
    req('h9F, 1, "R7 level request");
    ack("R6 level");
    eoi("R8 level broadcast");
    eoi("R8 edge no broadcast");

    // directed retirement suppresses broadcast
    regWr(3, 'h11FF);
    regRd(3, 'h11FF, "R9 directed bit kept");
    req('hA0, 1, "R7 level directed");
    ack("R6 directed");
    eoi("R8 directed no broadcast");
    regWr(3, 'h01FF);

    // deassert
    req('hB1, 1, "R10 level");
    opCycle(0, 0, 0, 0, 1, 'hB1, 0, "R10 deassert level");
    req('hB2, 0, "R10 edge");
    opCycle(0, 0, 0, 0, 1, 'hB2, 0, "R10 deassert edge ignored");
    ack("R10 edge still pending");
    eoi("R10 retire");

    // collision of request and acknowledge
    regWr(0, 'h00);
    req('h70, 0, "R12 setup");
    opCycle(1, 'h70, 0, 1, 0, 0, 0, "R12 collide");
    regRd(1, 'h70, "R12 in service");
    eoi("R12 retire");
    ack("R12 again");
    eoi("R12 retire again");

    // task priority masking of everything
    regWr(0, 'hF0);
    req('hE7, 0, "R5 full mask");
    ack("R5 full mask");
    regWr(0, 'h00);
    @(negedge clk);
    chk("R11 intReq after unmask", int'(intReq), 1);

    // ordering across words
    req('h05, 1, "R2 word0");
    req('h21, 0, "R2 word1");
    ack("R2 top word");
    eoi("R2 retire top");
    ack("R2 middle word");
    eoi("R2 retire middle");
    ack("R2 low word");
    eoi("R2 retire low");
    regRd(1, 'h00, "R3 all retired");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 all acks seen", ackQ.size(), 0);
    chk("R8 all broadcasts seen", bcastQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule